// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block translates virtual addresses for a fetch path. It has thirty-two translation entries. Each entry holds a virtual page tag, a physical page number, a domain identifier, two permission bits and a small attribute field. A request is compared against every valid entry at once. On a hit, the physical address and attributes are returned one cycle after the request is accepted, and memory is never touched.

On a miss, the block walks a single-level table by itself. It issues one descriptor read on a plain request/response memory port and writes the returned descriptor into a victim entry. It then answers the stalled request from that same descriptor. The request port stays not-ready for the whole walk.

The victim is chosen by a round-robin pointer that only visits unlocked entries. A lock base L protects entries 0 to L-1 from replacement and from invalidation. Every answer, whether from a hit or from a walk, is gated by a sixteen-domain access register. That register can force an abort. Clearing the global enable turns the block into a pass-through.

Top module: `fa_xlat_buf`

## Requirements
- R1: A lookup whose page tag matches a valid entry is a hit. One cycle after acceptance, `rsp_valid` is high and `rsp_pa` = {entry physical page, request offset[11:0]}. `rsp_attr` is the entry attribute. No memory request is made.
- R2: A lookup that misses with translation enabled raises `mem_req_valid` for exactly one cycle, in the cycle after acceptance. `mem_req_addr` = `tbl_base` + 4 × virtual page number. `req_ready` is low from acceptance until the response cycle, and it is never high while `mem_req_valid` is high.
- R3: The descriptor layout is: bits [29:10] physical page, [9:6] domain, [5:4] permission bits (bit 4 allows reads, bit 5 allows writes), [3:0] attribute. In the cycle after `mem_rsp_valid`, the stalled request is answered from this descriptor. The descriptor is also written into the buffer, so a later lookup of the same page hits.
- R4: The replacement pointer is 0 after reset. On each refill, the victim is the pointer, or L if the pointer is below L. The pointer then becomes victim+1, and it wraps from 31 back to L.
- R5: Entries with an index below `lock_base` (L) are never replaced and never invalidated. L is five bits wide, so entry 31 can never be locked.
- R6: A one-cycle pulse on `inval_all` clears every entry whose index is L or above. After it, a lookup of a page held only in those entries misses, and a lookup of a page held in a locked entry still hits.
- R7: The access code for domain d is `dom_acc[2d+1:2d]`. Code 11 allows the access with no check. Code 01 allows it only if the permission bit for the access type is set (`req_write` selects the bit). Codes 00 and 10 deny it. A denied access responds with `rsp_abort`=1, `rsp_pa`=0 and `rsp_attr`=0, whether it hit or was walked.
- R8: With `xlat_en` low, a request is answered one cycle after acceptance with `rsp_pa` = `req_va`, `rsp_attr`=0 and `rsp_abort`=0, and no walk takes place.
- R9: During and right after reset, `rsp_valid` and `mem_req_valid` are low, `req_ready` is high, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable; low selects pass-through |
| dom_acc | input | 32 | Two-bit access code for each of 16 domains |
| lock_base | input | 5 | Number of locked entries, counted from entry 0 |
| inval_all | input | 1 | Clears every unlocked entry |
| tbl_base | input | 32 | Byte address of the descriptor table |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Ready to accept a lookup |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 32 | Physical address, or 0 on abort |
| rsp_attr | output | 4 | Attributes, or 0 on abort |
| rsp_abort | output | 1 | Permission violation |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_desc | input | 30 | Descriptor data |

## Verification
The hardest states to reach are those where the replacement pointer sits below a newly raised lock base, or where an invalidate must spare exactly the locked entries. Neither can be set directly from the ports. The bench gets there by filling and overflowing the buffer with chains of misses, which moves the pointer to known positions. It then raises the lock base, invalidates, and probes both locked and unlocked pages. A reference model of the pointer and the entry contents, built from the requirements, predicts for every lookup whether it hits or walks. Permission outcomes are swept over all access codes, permission-bit pairs and access types, both on the walked response and on the later hit.

// File: rtl/fa_xlat_pkg.sv
package fa_xlat_pkg;
   localparam int unsigned DOM_W = 4;
   localparam int unsigned AP_W  = 2;

   typedef enum logic [1:0] {
      ACC_NONE   = 2'b00,
      ACC_CLIENT = 2'b01,
      ACC_RSVD   = 2'b10,
      ACC_MGR    = 2'b11
   } acc_code_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2
   } walk_st_t;
endpackage

// File: rtl/fa_xlat_array.sv
module fa_xlat_array
   import fa_xlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned ATTR_W  = 4,
   parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              inval_all,
   input  logic [IDX_W-1:0]  lock_base,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [VPN_W-1:0]  wr_ppn,
   input  logic [DOM_W-1:0]  wr_dom,
   input  logic [AP_W-1:0]   wr_ap,
   input  logic [ATTR_W-1:0] wr_attr,
   output logic              hit,
   output logic [VPN_W-1:0]  hit_ppn,
   output logic [DOM_W-1:0]  hit_dom,
   output logic [AP_W-1:0]   hit_ap,
   output logic [ATTR_W-1:0] hit_attr
);
   localparam int unsigned PAY_W = VPN_W + DOM_W + AP_W + ATTR_W;

   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] match;
   logic [VPN_W-1:0]   tag_q [ENTRIES];
   logic [PAY_W-1:0]   pay_q [ENTRIES];
   logic [PAY_W-1:0]   sel_pay;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
      logic wr_me;
      assign wr_me    = wr_en && (wr_idx == MY_IDX);
      assign match[e] = vld_q[e] && (tag_q[e] == lk_vpn);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[e] <= 1'b0;
         end else if (wr_me) begin
            vld_q[e] <= 1'b1;
         end else if (inval_all && (MY_IDX >= lock_base)) begin
            vld_q[e] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_me) begin
            tag_q[e] <= wr_vpn;
            pay_q[e] <= {wr_ppn, wr_dom, wr_ap, wr_attr};
         end
      end
   end

   always_comb begin
      sel_pay = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         sel_pay = sel_pay | ({PAY_W{match[i]}} & pay_q[i]);
      end
   end

   assign hit = |match;
   assign {hit_ppn, hit_dom, hit_ap, hit_attr} = sel_pay;

   // R1
   unique_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R5
   lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx >= lock_base));
endmodule

// File: rtl/fa_xlat_victim.sv
module fa_xlat_victim #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned IDX_W   = $clog2(ENTRIES),
   parameter bit          LOCK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lock_base,
   input  logic             adv,
   output logic [IDX_W-1:0] victim
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] floor_idx;
   logic [IDX_W-1:0] ptr_nxt;

   if (LOCK_EN) begin : g_locking
      assign floor_idx = lock_base;
   end else begin : g_plain
      assign floor_idx = '0;
   end

   assign victim  = (ptr_q < floor_idx) ? floor_idx : ptr_q;
   assign ptr_nxt = (victim == LAST) ? floor_idx : victim + IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv) begin
         ptr_q <= ptr_nxt;
      end
   end
endmodule

// File: rtl/fa_xlat_perm.sv
module fa_xlat_perm
   import fa_xlat_pkg::*;
#(
   parameter int unsigned DOM_N = 16
) (
   input  logic [2*DOM_N-1:0] dom_acc,
   input  logic [DOM_W-1:0]   dom,
   input  logic [AP_W-1:0]    ap,
   input  logic               is_write,
   output logic               allow
);
   acc_code_t code;

   assign code = acc_code_t'(dom_acc[{dom, 1'b0} +: 2]);

   always_comb begin
      unique case (code)
         ACC_MGR:    allow = 1'b1;
         ACC_CLIENT: allow = is_write ? ap[1] : ap[0];
         default:    allow = 1'b0;
      endcase
   end
endmodule

// File: rtl/fa_xlat_buf.sv
module fa_xlat_buf
   import fa_xlat_pkg::*;
#(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PAGE_W  = 12,
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned ATTR_W  = 4,
   parameter int unsigned DOM_N   = 16,
   localparam int unsigned VPN_W  = VA_W - PAGE_W,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned DESC_W = VPN_W + DOM_W + AP_W + ATTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlat_en,
   input  logic [2*DOM_N-1:0] dom_acc,
   input  logic [IDX_W-1:0]  lock_base,
   input  logic              inval_all,
   input  logic [VA_W-1:0]   tbl_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic [VA_W-1:0]   rsp_pa,
   output logic [ATTR_W-1:0] rsp_attr,
   output logic              rsp_abort,
   output logic              mem_req_valid,
   output logic [VA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DESC_W-1:0] mem_rsp_desc
);
   if (ENTRIES < 2 || ENTRIES != (1 << IDX_W)) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (PAGE_W < 1 || PAGE_W >= VA_W) begin : g_bad_page
      $error("PAGE_W must lie strictly between 0 and VA_W");
   end
   if (DOM_N != (1 << DOM_W)) begin : g_bad_dom
      $error("DOM_N must match the domain identifier width");
   end

   walk_st_t st_q;
   logic [VA_W-1:0] va_q;
   logic            wr_q;

   logic              accept;
   logic              in_idle;
   logic              hit;
   logic [VPN_W-1:0]  hit_ppn;
   logic [DOM_W-1:0]  hit_dom;
   logic [AP_W-1:0]   hit_ap;
   logic [ATTR_W-1:0] hit_attr;

   logic [VPN_W-1:0]  d_ppn;
   logic [DOM_W-1:0]  d_dom;
   logic [AP_W-1:0]   d_ap;
   logic [ATTR_W-1:0] d_attr;

   logic [VPN_W-1:0]  s_ppn;
   logic [DOM_W-1:0]  s_dom;
   logic [AP_W-1:0]   s_ap;
   logic [ATTR_W-1:0] s_attr;
   logic [PAGE_W-1:0] s_off;
   logic              s_write;
   logic              allow;

   logic              refill;
   logic [IDX_W-1:0]  victim;

   assign in_idle   = (st_q == ST_IDLE);
   assign req_ready = in_idle;
   assign accept    = req_valid && in_idle;
   assign refill    = (st_q == ST_WAIT) && mem_rsp_valid;

   assign {d_ppn, d_dom, d_ap, d_attr} = mem_rsp_desc;

   assign s_ppn   = in_idle ? hit_ppn  : d_ppn;
   assign s_dom   = in_idle ? hit_dom  : d_dom;
   assign s_ap    = in_idle ? hit_ap   : d_ap;
   assign s_attr  = in_idle ? hit_attr : d_attr;
   assign s_off   = in_idle ? req_va[PAGE_W-1:0] : va_q[PAGE_W-1:0];
   assign s_write = in_idle ? req_write : wr_q;

   assign mem_req_valid = (st_q == ST_FETCH);
   assign mem_req_addr  = tbl_base + (VA_W'(va_q[VA_W-1:PAGE_W]) << 2);

   fa_xlat_array #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .ATTR_W  (ATTR_W),
      .IDX_W   (IDX_W)
   ) array_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (req_va[VA_W-1:PAGE_W]),
      .inval_all (inval_all),
      .lock_base (lock_base),
      .wr_en     (refill),
      .wr_idx    (victim),
      .wr_vpn    (va_q[VA_W-1:PAGE_W]),
      .wr_ppn    (d_ppn),
      .wr_dom    (d_dom),
      .wr_ap     (d_ap),
      .wr_attr   (d_attr),
      .hit       (hit),
      .hit_ppn   (hit_ppn),
      .hit_dom   (hit_dom),
      .hit_ap    (hit_ap),
      .hit_attr  (hit_attr)
   );

   fa_xlat_victim #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W),
      .LOCK_EN (1'b1)
   ) victim_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_base (lock_base),
      .adv       (refill),
      .victim    (victim)
   );

   fa_xlat_perm #(
      .DOM_N (DOM_N)
   ) perm_i (
      .dom_acc  (dom_acc),
      .dom      (s_dom),
      .ap       (s_ap),
      .is_write (s_write),
      .allow    (allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_pa    <= '0;
         rsp_attr  <= '0;
         rsp_abort <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  va_q <= req_va;
                  wr_q <= req_write;
                  if (!xlat_en) begin
                     rsp_valid <= 1'b1;
                     rsp_pa    <= req_va;
                     rsp_attr  <= '0;
                     rsp_abort <= 1'b0;
                  end else if (hit) begin
                     rsp_valid <= 1'b1;
                     rsp_pa    <= allow ? {s_ppn, s_off} : '0;
                     rsp_attr  <= allow ? s_attr : '0;
                     rsp_abort <= !allow;
                  end else begin
                     st_q <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_pa    <= allow ? {s_ppn, s_off} : '0;
                  rsp_attr  <= allow ? s_attr : '0;
                  rsp_abort <= !allow;
                  st_q      <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   walk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R2
   miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && xlat_en && !hit) |=> (mem_req_valid && !rsp_valid));

   // R1
   hit_nowalk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && xlat_en && hit) |=> (rsp_valid && !mem_req_valid));

   // R8
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !xlat_en) |=> (rsp_valid && !rsp_abort && rsp_pa == $past(req_va)));

   // R3
   refill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refill |=> (rsp_valid && req_ready));

   // R7
   abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_abort) |-> (rsp_pa == '0 && rsp_attr == '0));
endmodule

// File: tb/fa_xlat_buf_tb_top.sv
module fa_xlat_buf_tb_top;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlat_en = 1'b0;
   logic [31:0] dom_acc = 32'hFFFF_FFFF;
   logic [4:0]  lock_base = 5'd0;
   logic        inval_all = 1'b0;
   logic [31:0] tbl_base = 32'h0010_0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_pa;
   logic [3:0]  rsp_attr;
   logic        rsp_abort;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [29:0] mem_rsp_desc = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int walk_cnt = 0;
   int stall_bad = 0;
   int cd = 0;
   logic [31:0] last_addr = '0;
   logic [1:0]  ap_sel = 2'b11;

   logic [19:0] m_vpn [N];
   bit          m_v   [N];
   logic [1:0]  m_ap  [N];
   int          rr = 0;

   fa_xlat_buf dut_i (
      .clk (clk), .rst_n (rst_n), .xlat_en (xlat_en), .dom_acc (dom_acc),
      .lock_base (lock_base), .inval_all (inval_all), .tbl_base (tbl_base),
      .req_valid (req_valid), .req_ready (req_ready), .req_va (req_va),
      .req_write (req_write), .rsp_valid (rsp_valid), .rsp_pa (rsp_pa),
      .rsp_attr (rsp_attr), .rsp_abort (rsp_abort),
      .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid), .mem_rsp_desc (mem_rsp_desc)
   );

   always #4 clk = ~clk;

   function automatic logic [19:0] ppn_f(input logic [19:0] v);
      return v ^ 20'h5A5A5;
   endfunction

   function automatic logic [3:0] attr_f(input logic [19:0] v);
      return v[3:0] ^ 4'h9;
   endfunction

   function automatic bit allowed(input logic [1:0] code, input logic [1:0] ap, input bit wr);
      if (code == 2'b11) return 1'b1;
      if (code == 2'b01) return wr ? ap[1] : ap[0];
      return 1'b0;
   endfunction

   // descriptor memory: fixed latency of three cycles
   always @(negedge clk) begin
      logic [19:0] v;
      mem_rsp_valid = 1'b0;
      if (cd > 0) begin
         cd--;
         if (cd == 0) begin
            v = 20'((last_addr - tbl_base) >> 2);
            mem_rsp_valid = 1'b1;
            mem_rsp_desc  = {ppn_f(v), v[3:0], ap_sel, attr_f(v)};
         end
      end
      if (mem_req_valid) begin
         walk_cnt++;
         last_addr = mem_req_addr;
         cd = 3;
         if (req_ready) stall_bad++;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic [31:0] va, input bit wr, output logic [31:0] pa,
                         output logic [3:0] at, output bit ab, output int walks, output bit tmo);
      int w0;
      int t;
      w0 = walk_cnt;
      @(negedge clk);
      req_va = va; req_write = wr; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!rsp_valid && t < 50) begin
         @(negedge clk);
         t++;
      end
      tmo = (t >= 50);
      pa = rsp_pa; at = rsp_attr; ab = rsp_abort;
      walks = walk_cnt - w0;
   endtask

   task automatic xact(input logic [19:0] vpn, input logic [11:0] off, input bit wr, input string tag);
      int hi;
      int vic;
      int exp_w;
      int walks;
      logic [1:0] ap_e;
      logic [1:0] code;
      bit ok;
      bit ab;
      bit tmo;
      logic [31:0] pa;
      logic [31:0] exp_pa;
      logic [3:0] at;
      logic [3:0] exp_at;
      hi = -1;
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) hi = i;
      if (hi < 0) begin
         vic = (rr < int'(lock_base)) ? int'(lock_base) : rr;
         m_vpn[vic] = vpn; m_v[vic] = 1'b1; m_ap[vic] = ap_sel;
         rr = (vic == N - 1) ? int'(lock_base) : vic + 1;
         exp_w = 1; ap_e = ap_sel;
      end else begin
         exp_w = 0; ap_e = m_ap[hi];
      end
      code = dom_acc[{vpn[3:0], 1'b0} +: 2];
      ok = allowed(code, ap_e, wr);
      exp_pa = ok ? {ppn_f(vpn), off} : 32'h0;
      exp_at = ok ? attr_f(vpn) : 4'h0;
      access({vpn, off}, wr, pa, at, ab, walks, tmo);
      chk(!tmo, {tag, " response timeout"}, 32'(tmo), 32'h0);
      chk(walks == exp_w, {tag, " walk count"}, 32'(walks), 32'(exp_w));
      if (exp_w == 1)
         chk(last_addr == tbl_base + {10'h0, vpn, 2'b00}, "R2 descriptor address",
             last_addr, tbl_base + {10'h0, vpn, 2'b00});
      chk(ab == !ok, {tag, " R7 abort"}, 32'(ab), 32'(!ok));
      chk(pa == exp_pa, {tag, " pa"}, pa, exp_pa);
      chk(at == exp_at, {tag, " attr"}, 32'(at), 32'(exp_at));
   endtask

   task automatic invalidate();
      @(negedge clk);
      inval_all = 1'b1;
      @(negedge clk);
      inval_all = 1'b0;
      for (int i = 0; i < N; i++) if (i >= int'(lock_base)) m_v[i] = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] pa;
      logic [3:0] at;
      bit ab;
      bit tmo;
      int walks;
      logic [19:0] lk [4];
      int idx;

      for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_vpn[i] = '0; m_ap[i] = '0; end

      // R9 reset state
      repeat (4) @(negedge clk);
      chk(rsp_valid == 1'b0, "R9 rsp_valid in reset", 32'(rsp_valid), 32'h0);
      chk(mem_req_valid == 1'b0, "R9 mem_req_valid in reset", 32'(mem_req_valid), 32'h0);
      chk(req_ready == 1'b1, "R9 req_ready in reset", 32'(req_ready), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R9 after reset", 32'({req_ready, rsp_valid}), 32'h2);

      // R8 pass-through sweep
      for (int i = 0; i < 8; i++) begin
         logic [31:0] va;
         va = 32'h1234_5000 + 32'(i) * 32'h0101_0033;
         access(va, i[0], pa, at, ab, walks, tmo);
         chk(!tmo && pa == va, "R8 bypass pa", pa, va);
         chk(at == 4'h0 && !ab, "R8 bypass attr/abort", 32'({at, ab}), 32'h0);
         chk(walks == 0, "R8 bypass walks", 32'(walks), 32'h0);
      end

      // R9 first lookups after reset miss; R3 refill fills entries 0..31
      xlat_en = 1'b1;
      for (int p = 0; p < N; p++) xact(20'(p * 37 + 5), 12'(p * 131), 1'b0, "R3 fill");
      for (int p = 0; p < N; p++) xact(20'(p * 37 + 5), 12'(p * 77 + 1), p[0], "R1 hit");
      for (int p = N; p < N + 16; p++) xact(20'(p * 37 + 5), 12'h3C0, 1'b0, "R4 overflow");
      for (int p = 0; p < 20; p++) xact(20'(p * 37 + 5), 12'h044, 1'b1, "R4 re-fetch");

      // R5/R6 lock four entries, then invalidate
      lock_base = 5'd4;
      for (int i = 0; i < 4; i++) lk[i] = m_vpn[i];
      invalidate();
      for (int i = 0; i < 4; i++) xact(lk[i], 12'hABC, 1'b0, "R5 locked survives invalidate");
      xact(m_vpn[4], 12'h010, 1'b0, "R6 unlocked cleared");
      for (int p = 0; p < 60; p++) xact(20'(20'h40000 + p * 3), 12'(p), 1'b0, "R4 wrap to lock base");
      for (int i = 0; i < 4; i++) xact(lk[i], 12'h123, 1'b1, "R5 locked never replaced");

      // R4 pointer below a raised lock base
      lock_base = 5'd20;
      for (int p = 0; p < 30; p++) xact(20'(20'h60000 + p * 5), 12'h7F0, 1'b0, "R4 pointer below lock base");
      invalidate();
      xact(m_vpn[19], 12'h001, 1'b0, "R5 entry below lock base kept");
      xact(m_vpn[25], 12'h002, 1'b0, "R6 entry above lock base cleared");

      // R7 permission sweep: every code, permission pair and access type
      lock_base = 5'd0;
      invalidate();
      idx = 0;
      for (int c = 0; c < 4; c++) begin
         for (int a = 0; a < 4; a++) begin
            for (int w = 0; w < 2; w++) begin
               logic [19:0] v;
               dom_acc = {16{2'(c)}};
               ap_sel = 2'(a);
               v = 20'(20'h80000 + idx * 17);
               idx++;
               xact(v, 12'h5A0, w[0], "R7 walked");
               ap_sel = 2'(3 - a);
               xact(v, 12'h0A5, w[0], "R7 hit");
            end
         end
      end

      // R7 one domain denied while others are open, on a resident entry
      dom_acc = 32'hFFFF_FFFF;
      ap_sel = 2'b11;
      xact(20'h90005, 12'h111, 1'b0, "R7 domain 5 open");
      dom_acc = 32'hFFFF_F3FF;
      xact(20'h90005, 12'h222, 1'b0, "R7 domain 5 denied on hit");
      xact(20'h90006, 12'h333, 1'b0, "R7 neighbour domain unaffected");

      // R2 ready never high while the walk request is out
      chk(stall_bad == 0, "R2 ready during walk", 32'(stall_bad), 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule